// File: doc/BRIEF.md
# Byte Dot-Product Accumulate Unit

This execution unit carries out one packed-byte DSP operation. Each of its two 32-bit source operands holds four unsigned byte lanes. The unit takes the two lowest lanes of each operand and multiplies each lane by the lane in the same position of the other operand. It adds the two 16-bit products together. It then adds that sum into one of four 64-bit accumulators. Each accumulator is stored as a pair of 32-bit halves: the high half holds bits 63..32 and the low half holds bits 31..0.

The unit decodes a 32-bit instruction word that is qualified by a valid strobe. It gives out the two register index fields so that a register file can supply the operand values. It checks a DSP-enable input before it commits anything. If the word is not the expected encoding, the unit raises a reserved-instruction exception. If the word is correct but DSP use is disabled, it raises a DSP-disabled exception. In both cases no accumulator changes.

Software can load either half of any accumulator through a write port. It can observe any accumulator through a combinational read port. The addition wraps modulo 2^64, and no flags are produced.

Top module: `bdp_acc_unit`

## Requirements
- R1: An instruction word is recognised only when bits 31..26 equal 001000 and bits 13..0 equal 11_000_010_111_111 (0x30BF). Any other word presented with `instr_valid` sets `exc_reserved` in the next cycle and leaves all accumulators unchanged.
- R2: `idx_t` always shows instruction bits 25..21 and `idx_s` always shows bits 20..16, combinationally, whether or not the word is valid.
- R3: The addend is `s[15:8]*t[15:8] + s[7:0]*t[7:0]`, computed as unsigned values. Operand bits 31..16 have no effect on the result.
- R4: A recognised, enabled instruction adds the addend into the pair selected by instruction bits 15..14 (0 to 3) on the next clock edge. The other three pairs keep their values.
- R5: The 64-bit accumulation wraps modulo 2^64, and the carry out of bit 63 is discarded.
- R6: A recognised word presented while `dsp_enable` is low sets `exc_dsp_off` in the next cycle and changes no accumulator. An unrecognised word reports only `exc_reserved`, whatever the state of `dsp_enable`. The two flags are never high together.
- R7: Both exception flags are low in the cycle after a cycle with no valid instruction, and in the cycle after a successful accumulation.
- R8: A synchronous reset clears all four pairs and both exception flags.
- R9: With `wr_en` high, `wr_data` is loaded on the next edge into the high half (`wr_hi`=1) or the low half (`wr_hi`=0) of pair `wr_sel`. The other half keeps its value.
- R10: When a write and an accumulation target the same pair in the same cycle, the accumulated 64-bit sum is formed first. The written half is then replaced by `wr_data`, and the other half keeps its half of the sum.
- R11: `rd_hi`/`rd_lo` show pair `rd_sel` combinationally, with no clock edge needed between a change of `rd_sel` and the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Instruction word is presented this cycle |
| instr_word | input | 32 | Instruction encoding |
| dsp_enable | input | 1 | DSP resources usable |
| opnd_s_val | input | 32 | Value of the register named by `idx_s` |
| opnd_t_val | input | 32 | Value of the register named by `idx_t` |
| idx_s | output | 5 | Register index taken from bits 20..16 |
| idx_t | output | 5 | Register index taken from bits 25..21 |
| wr_en | input | 1 | Direct accumulator half write |
| wr_sel | input | 2 | Pair selected for the write |
| wr_hi | input | 1 | 1 writes the high half, 0 writes the low half |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Pair selected for the read |
| rd_hi | output | 32 | High half of the read pair |
| rd_lo | output | 32 | Low half of the read pair |
| exc_reserved | output | 1 | Unrecognised encoding seen in the previous cycle |
| exc_dsp_off | output | 1 | Recognised instruction seen while DSP was disabled |

## Verification
The properties that check stability assume that no direct write lands in the same cycle as a rejected instruction. The properties that check the sum assume the same for an accepted one. The stimulus therefore drives write-port traffic only in cycles of its own, apart from one deliberate overlap that exercises R10 and falls outside those antecedents. Operand sweeps walk both byte lanes across 0 to 255 in steps of 15, so 0x00 and 0xFF are always included. They fill the ignored upper half-word with random bits, and the walks repeat for every accumulator select. Rejection checks corrupt each fixed encoding bit one at a time.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
    localparam int WORD_W   = 32;
    localparam int ACC_W    = 2 * WORD_W;
    localparam int HALF_W   = ACC_W / 2;
    localparam int NUM_ACC  = 4;
    localparam int SEL_W    = $clog2(NUM_ACC);
    localparam int IDX_W    = 5;

    localparam logic [5:0]  MAJOR_OP  = 6'b001000;
    localparam logic [13:0] MINOR_TAG = 14'b11_000_010_111_111;

    typedef logic [ACC_W-1:0] acc_word_t;

    typedef struct packed {
        logic             match;
        logic [IDX_W-1:0] idx_t;
        logic [IDX_W-1:0] idx_s;
        logic [SEL_W-1:0] acc_sel;
    } dec_t;

    typedef struct packed {
        acc_word_t [NUM_ACC-1:0] pair;
    } bank_t;

    typedef struct packed {
        logic exc_res;
        logic exc_off;
    } flag_t;
endpackage

// File: rtl/bdp_decode.sv
module bdp_decode
    import bdp_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output dec_t              dec
);
    always_comb begin
        dec.match   = (word[31:26] == MAJOR_OP) && (word[13:0] == MINOR_TAG);
        dec.idx_t   = word[25:21];
        dec.idx_s   = word[20:16];
        dec.acc_sel = word[15:14];
    end
endmodule

// File: rtl/bdp_dot.sv
module bdp_dot #(
    parameter int LANE_W = 8,
    parameter int LANES  = 2,
    parameter int IN_W   = 16,
    parameter int OUT_W  = 64
) (
    input  logic [IN_W-1:0]  a,
    input  logic [IN_W-1:0]  b,
    output logic [OUT_W-1:0] sum
);
    localparam int PROD_W = 2 * LANE_W;
    localparam int SUM_W  = PROD_W + $clog2(LANES) + 1;

    logic [LANES-1:0][PROD_W-1:0] prod;
    logic [SUM_W-1:0]             total;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign prod[g] = PROD_W'(a[g*LANE_W +: LANE_W]) * PROD_W'(b[g*LANE_W +: LANE_W]);
    end

    always_comb begin
        total = '0;
        for (int k = 0; k < LANES; k++) begin
            total = total + SUM_W'(prod[k]);
        end
    end

    assign sum = OUT_W'(total);
endmodule

// File: rtl/bdp_acc_bank.sv
module bdp_acc_bank
    import bdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_en,
    input  logic [SEL_W-1:0]  upd_sel,
    input  acc_word_t         upd_val,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic              wr_hi,
    input  logic [HALF_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [HALF_W-1:0] rd_hi,
    output logic [HALF_W-1:0] rd_lo,
    output logic [NUM_ACC*ACC_W-1:0] acc_flat
);
    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (upd_en) begin
            st_d.pair[upd_sel] = st_q.pair[upd_sel] + upd_val;
        end
        if (wr_en) begin
            if (wr_hi) begin
                st_d.pair[wr_sel][ACC_W-1:HALF_W] = wr_data;
            end else begin
                st_d.pair[wr_sel][HALF_W-1:0] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_hi    = st_q.pair[rd_sel][ACC_W-1:HALF_W];
    assign rd_lo    = st_q.pair[rd_sel][HALF_W-1:0];
    assign acc_flat = st_q;
endmodule

// File: rtl/bdp_acc_unit.sv
module bdp_acc_unit
    import bdp_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [WORD_W-1:0] instr_word,
    input  logic              dsp_enable,
    input  logic [WORD_W-1:0] opnd_s_val,
    input  logic [WORD_W-1:0] opnd_t_val,
    output logic [IDX_W-1:0]  idx_s,
    output logic [IDX_W-1:0]  idx_t,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic              wr_hi,
    input  logic [HALF_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [HALF_W-1:0] rd_hi,
    output logic [HALF_W-1:0] rd_lo,
    output logic              exc_reserved,
    output logic              exc_dsp_off
);
    localparam int USED_W = LANE_W * LANES;

    dec_t       dec;
    acc_word_t  addend;
    logic       fire;
    flag_t      flg_d, flg_q;
    logic [NUM_ACC*ACC_W-1:0] acc_flat;
    logic       unused_upper;

    bdp_decode u_dec (
        .word (instr_word),
        .dec  (dec)
    );

    bdp_dot #(
        .LANE_W (LANE_W),
        .LANES  (LANES),
        .IN_W   (USED_W),
        .OUT_W  (ACC_W)
    ) u_dot (
        .a   (opnd_s_val[USED_W-1:0]),
        .b   (opnd_t_val[USED_W-1:0]),
        .sum (addend)
    );

    assign unused_upper = ^{opnd_s_val[WORD_W-1:USED_W], opnd_t_val[WORD_W-1:USED_W]};

    assign fire = instr_valid && dec.match && dsp_enable;

    bdp_acc_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .upd_en   (fire),
        .upd_sel  (dec.acc_sel),
        .upd_val  (addend),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_hi    (wr_hi),
        .wr_data  (wr_data),
        .rd_sel   (rd_sel),
        .rd_hi    (rd_hi),
        .rd_lo    (rd_lo),
        .acc_flat (acc_flat)
    );

    always_comb begin
        flg_d         = '0;
        flg_d.exc_res = instr_valid && !dec.match;
        flg_d.exc_off = instr_valid && dec.match && !dsp_enable;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flg_q <= '0;
        end else begin
            flg_q <= flg_d;
        end
    end

    assign idx_s        = dec.idx_s;
    assign idx_t        = dec.idx_t;
    assign exc_reserved = flg_q.exc_res;
    assign exc_dsp_off  = flg_q.exc_off;
endmodule

// File: rtl/bdp_acc_chk.sv
module bdp_acc_chk
    import bdp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              instr_valid,
    input logic [WORD_W-1:0] instr_word,
    input logic              dsp_enable,
    input logic [15:0]       lo_s,
    input logic [15:0]       lo_t,
    input logic              wr_en,
    input logic              exc_reserved,
    input logic              exc_dsp_off,
    input logic [NUM_ACC*ACC_W-1:0] acc_flat
);
    logic      good_word;
    acc_word_t exp_add;

    assign good_word = {instr_word[31:26], instr_word[13:0]} == {MAJOR_OP, MINOR_TAG};
    assign exp_add   = ACC_W'({2'b00, lo_s[15:8]} * {2'b00, lo_t[15:8]})
                     + ACC_W'({2'b00, lo_s[7:0]} * {2'b00, lo_t[7:0]});

    assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(exc_reserved && exc_dsp_off));

    assert_reserved_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && !good_word && !wr_en) |=> (exc_reserved && $stable(acc_flat)));

    assert_disabled_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && good_word && !dsp_enable && !wr_en) |=> (exc_dsp_off && $stable(acc_flat)));

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> (!exc_reserved && !exc_dsp_off));

    assert_reset_clear_R8: assert property (@(posedge clk)
        rst |=> (acc_flat == '0 && !exc_reserved && !exc_dsp_off));

    for (genvar k = 0; k < NUM_ACC; k++) begin : g_pair
        assert_wrap_sum_R5: assert property (@(posedge clk) disable iff (rst)
            (instr_valid && good_word && dsp_enable && !wr_en && instr_word[15:14] == SEL_W'(k))
            |=> (acc_flat[k*ACC_W +: ACC_W] == acc_word_t'($past(acc_flat[k*ACC_W +: ACC_W]) + $past(exp_add))));
    end
endmodule

bind bdp_acc_unit bdp_acc_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .instr_valid  (instr_valid),
    .instr_word   (instr_word),
    .dsp_enable   (dsp_enable),
    .lo_s         (opnd_s_val[15:0]),
    .lo_t         (opnd_t_val[15:0]),
    .wr_en        (wr_en),
    .exc_reserved (exc_reserved),
    .exc_dsp_off  (exc_dsp_off),
    .acc_flat     (acc_flat)
);

// File: tb/sim_bdp_acc_unit.sv
`timescale 1ns/100ps
module sim_bdp_acc_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic        dsp_enable = 1'b1;
    logic [31:0] opnd_s_val = '0;
    logic [31:0] opnd_t_val = '0;
    logic [4:0]  idx_s, idx_t;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic        wr_hi = 1'b0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = '0;
    logic [31:0] rd_hi, rd_lo;
    logic        exc_reserved, exc_dsp_off;

    int n_cmp = 0;
    int n_bad = 0;
    logic [63:0] model [4];

    always #2 clk = ~clk;

    bdp_acc_unit u0 (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
        .dsp_enable(dsp_enable), .opnd_s_val(opnd_s_val), .opnd_t_val(opnd_t_val),
        .idx_s(idx_s), .idx_t(idx_t), .wr_en(wr_en), .wr_sel(wr_sel), .wr_hi(wr_hi),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_hi(rd_hi), .rd_lo(rd_lo),
        .exc_reserved(exc_reserved), .exc_dsp_off(exc_dsp_off)
    );

    function automatic logic [31:0] mk(input logic [4:0] t, input logic [4:0] s, input logic [1:0] sel);
        return {6'b001000, t, s, sel, 14'h30BF};
    endfunction

    function automatic logic [63:0] dotv(input logic [31:0] s, input logic [31:0] t);
        return 64'(s[15:8]) * 64'(t[15:8]) + 64'(s[7:0]) * 64'(t[7:0]);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_pairs(input string req);
        for (int k = 0; k < 4; k++) begin
            rd_sel = 2'(k);
            #0.2;
            chk(req, {rd_hi, rd_lo}, model[k]);
        end
    endtask

    task automatic chk_flags(input string req, input logic er, input logic eo);
        chk(req, {62'd0, exc_reserved, exc_dsp_off}, {62'd0, er, eo});
    endtask

    // One cycle of stimulus driven at a falling edge, released at the next falling edge.
    task automatic step(input logic v, input logic [31:0] w, input logic [31:0] s,
                        input logic [31:0] t, input logic en, input logic we,
                        input logic [1:0] ws, input logic wh, input logic [31:0] wd);
        @(negedge clk);
        instr_valid = v; instr_word = w; opnd_s_val = s; opnd_t_val = t;
        dsp_enable = en; wr_en = we; wr_sel = ws; wr_hi = wh; wr_data = wd;
        @(negedge clk);
        instr_valid = 1'b0; wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #400000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] s, t, w;
        for (int k = 0; k < 4; k++) model[k] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8: reset state
        chk_pairs("R8 reset pairs");
        chk_flags("R8 reset flags", 1'b0, 1'b0);

        // R2: index fields shown without a valid strobe
        for (int i = 0; i < 32; i += 7) begin
            instr_word = {6'h3F, 5'(i), 5'(31 - i), 16'hA5A5};
            #0.2;
            chk("R2 index fields", {54'd0, idx_t, idx_s}, {54'd0, 5'(i), 5'(31 - i)});
        end

        // R3 R4 R11: lane sweeps over every accumulator select
        for (int sel = 0; sel < 4; sel++) begin
            for (int i = 0; i <= 255; i += 15) begin
                for (int j = 0; j <= 255; j += 15) begin
                    s = {16'($urandom), 8'(i), 8'(255 - i)};
                    t = {16'($urandom), 8'(j), 8'((i + j) & 255)};
                    step(1'b1, mk(5'(j), 5'(i), 2'(sel)), s, t, 1'b1, 1'b0, 2'd0, 1'b0, 32'd0);
                    model[sel] = model[sel] + dotv(s, t);
                    chk_flags("R7 flags after accept", 1'b0, 1'b0);
                    chk_pairs("R3 R4 R11 sweep");
                end
            end
        end

        // R3: upper halves alone change nothing in the sum
        step(1'b1, mk(5'd1, 5'd2, 2'd1), 32'hFFFF_0000, 32'hFFFF_0000, 1'b1, 1'b0, 2'd0, 1'b0, 32'd0);
        chk_pairs("R3 upper lanes ignored");

        // R9: direct half writes, then R5 wraparound with all-0xFF lanes
        step(1'b0, 32'd0, 32'd0, 32'd0, 1'b1, 1'b1, 2'd2, 1'b1, 32'hFFFF_FFFF);
        model[2][63:32] = 32'hFFFF_FFFF;
        chk_pairs("R9 write high half");
        step(1'b0, 32'd0, 32'd0, 32'd0, 1'b1, 1'b1, 2'd2, 1'b0, 32'hFFFF_0000);
        model[2][31:0] = 32'hFFFF_0000;
        chk_pairs("R9 write low half");
        step(1'b1, mk(5'd3, 5'd4, 2'd2), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0, 2'd0, 1'b0, 32'd0);
        model[2] = 64'hFFFF_FFFF_FFFF_0000 + 64'd130050;
        rd_sel = 2'd2;
        #0.2;
        chk("R5 wrap value", {rd_hi, rd_lo}, 64'h0000_0000_0000_FC02);
        for (int r = 0; r < 6; r++) begin
            step(1'b1, mk(5'd3, 5'd4, 2'd2), 32'h1234_FFFF, 32'h8765_FFFF, 1'b1, 1'b0, 2'd0, 1'b0, 32'd0);
            model[2] = model[2] + 64'd130050;
            chk_pairs("R5 repeated accumulate");
        end
        step(1'b0, 32'd0, 32'd0, 32'd0, 1'b1, 1'b1, 2'd0, 1'b1, 32'hFFFF_FFFF);
        model[0][63:32] = 32'hFFFF_FFFF;
        step(1'b0, 32'd0, 32'd0, 32'd0, 1'b1, 1'b1, 2'd0, 1'b0, 32'hFFFF_FFFF);
        model[0][31:0] = 32'hFFFF_FFFF;
        step(1'b1, mk(5'd0, 5'd0, 2'd0), 32'h0000_0001, 32'h0000_0001, 1'b1, 1'b0, 2'd0, 1'b0, 32'd0);
        model[0] = 64'd0;
        chk_pairs("R5 all-ones plus one");

        // R6: disabled resources
        step(1'b1, mk(5'd5, 5'd6, 2'd3), 32'h0000_FFFF, 32'h0000_FFFF, 1'b0, 1'b0, 2'd0, 1'b0, 32'd0);
        chk_flags("R6 disabled flag", 1'b0, 1'b1);
        chk_pairs("R6 disabled no update");
        step(1'b1, mk(5'd5, 5'd6, 2'd3) ^ 32'h1, 32'h0000_FFFF, 32'h0000_FFFF, 1'b0, 1'b0, 2'd0, 1'b0, 32'd0);
        chk_flags("R6 reserved precedence", 1'b1, 1'b0);
        chk_pairs("R6 bad word disabled no update");

        // R1: every fixed encoding bit corrupted in turn
        for (int b = 0; b < 32; b++) begin
            if (b < 14 || b > 25) begin
                w = mk(5'd7, 5'd8, 2'(b)) ^ (32'd1 << b);
                step(1'b1, w, 32'h0000_FFFF, 32'h0000_FFFF, 1'b1, 1'b0, 2'd0, 1'b0, 32'd0);
                chk_flags("R1 reserved flag", 1'b1, 1'b0);
                chk_pairs("R1 reserved no update");
            end
        end

        // R7: idle cycle clears flags
        step(1'b0, 32'd0, 32'd0, 32'd0, 1'b1, 1'b0, 2'd0, 1'b0, 32'd0);
        chk_flags("R7 idle flags", 1'b0, 1'b0);

        // R10: overlapping write and accumulate into one pair
        step(1'b0, 32'd0, 32'd0, 32'd0, 1'b1, 1'b1, 2'd1, 1'b1, 32'h0000_0010);
        model[1][63:32] = 32'h0000_0010;
        step(1'b0, 32'd0, 32'd0, 32'd0, 1'b1, 1'b1, 2'd1, 1'b0, 32'hFFFF_FFF0);
        model[1][31:0] = 32'hFFFF_FFF0;
        step(1'b1, mk(5'd9, 5'd9, 2'd1), 32'h0000_0004, 32'h0000_0004, 1'b1, 1'b1, 2'd1, 1'b0, 32'hCAFE_0000);
        model[1] = model[1] + 64'd16;
        model[1][31:0] = 32'hCAFE_0000;
        chk_pairs("R10 write low over sum");
        step(1'b1, mk(5'd9, 5'd9, 2'd1), 32'h0000_0100, 32'h0000_0100, 1'b1, 1'b1, 2'd1, 1'b1, 32'h0BAD_0000);
        model[1] = model[1] + 64'd1;
        model[1][63:32] = 32'h0BAD_0000;
        chk_pairs("R10 write high over sum");

        // R8: reset again clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 4; k++) model[k] = '0;
        chk_pairs("R8 second reset");
        chk_flags("R8 second reset flags", 1'b0, 1'b0);

        finish_run();
    end
endmodule